// File: doc/BRIEF.md
# Serial-Interface Byte Memory with Region Locking

This block is a serial-bus slave that fronts a byte-wide storage array held in an internal register array. A host selects it with an active-low select line, shifts a one-byte command in on the data input, adds a 16-bit address for array accesses, and then streams data in or out. Reads run on through the array without limit. Writes collect up to one 32-byte page in a staging buffer. When the host releases the select line, the staged bytes are committed during a self-timed busy window.

Writes are guarded three ways. A write enable latch must be set first. A two-bit region field in the status byte can lock the upper quarter, the upper half or the whole array. A write-protect pin blocks changes to the status byte. A pause input freezes the serial state in the middle of a transfer, so the host can leave the bus and come back to finish it. All serial pins are brought into the system clock domain through two-flop synchronisers. Serial clock edges are detected from the synchronised copy, so the serial clock must run well below the system clock (at least 8 system clocks per serial clock period). The array size is set by `ADDR_W`: the full 16K-byte part uses `ADDR_W = 14`, and the default is a smaller array for quick elaboration.

Top module: `sermem_spi_slave`

## Requirements
- R1: After reset the status byte reads 0x00, and `so_oe` stays low whenever `cs_n` is high.
- R2: The status byte is {4'b0000, lock[1:0] at bits 3:2, write-enable latch at bit 1, busy at bit 0} and is read with opcode 0x05. Opcode 0x06 sets the latch and opcode 0x04 clears it.
- R3: Opcode 0x03, followed by a 16-bit address of which only the low `ADDR_W` bits are used, returns bytes MSB first from consecutive addresses. The read wraps from the last address to address 0.
- R4: Opcode 0x02 with a 16-bit address stages data bytes. The byte column advances modulo 32 inside the same page. The page is written only if `cs_n` rises on a byte boundary after at least one data byte.
- R5: An array write or a status write that arrives while the latch is clear is discarded and starts no busy window.
- R6: With lock code 00 nothing is locked, 01 locks the top quarter of the address space, 10 locks the top half, and 11 locks everything. A write aimed at a locked page is discarded entirely, and the latch stays set.
- R7: Opcode 0x01 followed by a data byte loads the lock field from data bits 3:2, and only when `wp_n` is high at commit. With `wp_n` low the lock field and the latch are unchanged.
- R8: An accepted write sets busy for `WR_CYCLES` clocks. When busy ends, the latch is cleared.
- R9: While busy, every opcode except 0x05 is ignored. A read then never drives `so_oe`.
- R10: Raising `cs_n` in the middle of a byte aborts a pending write and resets the command decoder.
- R11: While `hold_n` is low and the device is selected, serial clock and data input edges are ignored, `so_oe` is low, and the transfer resumes intact when `hold_n` rises.
- R12: Data is sampled on rising and shifted out on falling serial clock edges, whether the clock idles low or high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low device select |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data from the host |
| hold_n | input | 1 | Active-low transfer pause |
| wp_n | input | 1 | Active-low status write protect |
| so | output | 1 | Serial data to the host |
| so_oe | output | 1 | Drive enable for `so`; low means high impedance |

## Verification
The bench aims at the points where a subtly wrong design still looks plausible. It writes four bytes starting at page column 30, so a design that lets the column carry into the next page corrupts a neighbouring page. It aborts a write three bits into the second data byte, which a design that commits on any select release would turn into a busy cycle. It pauses a read mid-byte while toggling the serial clock, so a design that does not gate edges during the pause returns a shifted byte. It also tries a status write with `wp_n` low, a read issued during busy, and random lock codes against random pages in both idle-clock polarities. A lock decoder with a swapped code would show up as missing or extra data in the page read back afterwards.

// File: rtl/sermem_pkg.sv
package sermem_pkg;

    localparam logic [7:0] OP_WRSR  = 8'h01;
    localparam logic [7:0] OP_WRITE = 8'h02;
    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_WRDI  = 8'h04;
    localparam logic [7:0] OP_RDSR  = 8'h05;
    localparam logic [7:0] OP_WREN  = 8'h06;

    typedef enum logic [2:0] {
        PH_CMD, PH_ADDR, PH_RDATA, PH_WDATA,
        PH_SRDATA, PH_SRFULL, PH_STOUT, PH_IGNORE
    } phase_e;

    typedef struct packed {
        logic [1:0] lock;
        logic       wel;
        logic       wip;
    } stat_t;

    function automatic logic [7:0] stat_byte(stat_t s);
        return {4'b0000, s.lock, s.wel, s.wip};
    endfunction

    // top2 = two most significant address bits of the target page
    function automatic logic region_locked(logic [1:0] lock, logic [1:0] top2);
        case (lock)
            2'b00:   return 1'b0;
            2'b01:   return top2 == 2'b11;
            2'b10:   return top2[1];
            default: return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/sermem_pin_sync.sv
module sermem_pin_sync (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    input  logic hold_n,
    input  logic wp_n,
    output logic sel,
    output logic desel_evt,
    output logic sck_rise,
    output logic sck_fall,
    output logic si_bit,
    output logic wp_ok,
    output logic held
);
    localparam logic [4:0] IDLE = 5'b10011; // {cs_n, sck, si, hold_n, wp_n}

    logic [4:0] m1, m2;
    logic       sck_q, sel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            m1    <= IDLE;
            m2    <= IDLE;
            sck_q <= 1'b0;
            sel_q <= 1'b0;
        end else begin
            m1    <= {cs_n, sck, si, hold_n, wp_n};
            m2    <= m1;
            sck_q <= m2[3];
            sel_q <= sel;
        end
    end

    assign sel       = ~m2[4];
    assign si_bit    = m2[2];
    assign wp_ok     = m2[0];
    assign held      = sel & ~m2[1];
    assign sck_rise  = sel & ~held & m2[3] & ~sck_q;
    assign sck_fall  = sel & ~held & ~m2[3] & sck_q;
    assign desel_evt = sel_q & ~sel;

endmodule

// File: rtl/sermem_wr_timer.sv
module sermem_wr_timer #(
    parameter int CYCLES = 2000,
    parameter int PAGE   = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    output logic                    busy,
    output logic                    done,
    output logic                    step_en,
    output logic [$clog2(PAGE)-1:0] step_idx
);
    localparam int CW = $clog2(CYCLES + 1);
    localparam int IW = $clog2(PAGE);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start && !busy) begin
            busy <= 1'b1;
            cnt  <= '0;
        end else if (busy) begin
            if (done) busy <= 1'b0;
            cnt <= cnt + 1'b1;
        end
    end

    assign done     = busy && (cnt == CW'(CYCLES - 1));
    assign step_en  = busy && (int'(cnt) < PAGE);
    assign step_idx = cnt[IW-1:0];

    assert_start_busy_R8: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);
    assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

endmodule

// File: rtl/sermem_array.sv
module sermem_array #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    localparam int DEPTH = 2 ** AW;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/sermem_spi_slave.sv
module sermem_spi_slave #(
    parameter int ADDR_W     = 10,
    parameter int PAGE_BYTES = 32,
    parameter int WR_CYCLES  = 2000
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    input  logic hold_n,
    input  logic wp_n,
    output logic so,
    output logic so_oe
);
    import sermem_pkg::*;

    localparam int IW = $clog2(PAGE_BYTES);

    logic sel, desel_evt, sck_rise, sck_fall, si_bit, wp_ok, held;
    logic wip, done, step_en;
    logic [IW-1:0] step_idx;

    sermem_pin_sync u_sync (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si),
        .hold_n(hold_n), .wp_n(wp_n), .sel(sel), .desel_evt(desel_evt),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .si_bit(si_bit),
        .wp_ok(wp_ok), .held(held)
    );

    phase_e              phase;
    logic [2:0]          bit_cnt;
    logic [6:0]          sh;
    logic [7:0]          addr_hi;
    logic                addr_stage, is_wr, cyc_arr, so_r;
    logic [ADDR_W-1:0]   addr;
    logic [PAGE_BYTES-1:0] pmask;
    logic [7:0]          pbuf [PAGE_BYTES];
    logic [1:0]          lock, lock_new;
    logic                wel;
    logic [7:0]          byte_in, rd_data, tx_byte;
    logic                byte_done, page_locked, wr_go, take_wdata;
    logic                mem_we;
    logic [ADDR_W-1:0]   mem_waddr;
    stat_t               st;

    assign st          = '{lock: lock, wel: wel, wip: wip};
    assign byte_in     = {sh, si_bit};
    assign byte_done   = sck_rise && (bit_cnt == 3'd7);
    assign tx_byte     = (phase == PH_STOUT) ? stat_byte(st) : rd_data;
    assign page_locked = region_locked(lock, addr[ADDR_W-1 -: 2]);
    assign take_wdata  = byte_done && (phase == PH_WDATA);

    // commit decision uses the pre-deselect phase and bit position
    assign wr_go = desel_evt && (bit_cnt == 3'd0) && wel && !wip &&
                   (((phase == PH_WDATA) && (|pmask) && !page_locked) ||
                    ((phase == PH_SRFULL) && wp_ok));

    sermem_wr_timer #(.CYCLES(WR_CYCLES), .PAGE(PAGE_BYTES)) u_timer (
        .clk(clk), .rst(rst), .start(wr_go), .busy(wip), .done(done),
        .step_en(step_en), .step_idx(step_idx)
    );

    assign mem_we    = step_en && cyc_arr && pmask[step_idx];
    assign mem_waddr = {addr[ADDR_W-1:IW], step_idx};

    sermem_array #(.AW(ADDR_W)) u_array (
        .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(pbuf[step_idx]),
        .raddr(addr), .rdata(rd_data)
    );

    always_ff @(posedge clk) begin
        if (take_wdata) pbuf[addr[IW-1:0]] <= byte_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= PH_CMD;
            bit_cnt    <= '0;
            sh         <= '0;
            addr_hi    <= '0;
            addr_stage <= 1'b0;
            is_wr      <= 1'b0;
            cyc_arr    <= 1'b0;
            addr       <= '0;
            pmask      <= '0;
            lock       <= 2'b00;
            lock_new   <= 2'b00;
            wel        <= 1'b0;
            so_r       <= 1'b0;
        end else begin
            if (done) wel <= 1'b0;
            if (wr_go) begin
                cyc_arr <= (phase == PH_WDATA);
                if (phase == PH_SRFULL) lock <= lock_new;
            end
            if (!sel) begin
                phase      <= PH_CMD;
                bit_cnt    <= '0;
                addr_stage <= 1'b0;
            end else if (sck_rise) begin
                bit_cnt <= bit_cnt + 3'd1;
                sh      <= byte_in[6:0];
                if (byte_done) begin
                    case (phase)
                        PH_CMD: begin
                            if (wip && byte_in != OP_RDSR) phase <= PH_IGNORE;
                            else begin
                                case (byte_in)
                                    OP_WREN: begin wel <= 1'b1; phase <= PH_IGNORE; end
                                    OP_WRDI: begin wel <= 1'b0; phase <= PH_IGNORE; end
                                    OP_RDSR: phase <= PH_STOUT;
                                    OP_WRSR: phase <= PH_SRDATA;
                                    OP_READ: begin phase <= PH_ADDR; is_wr <= 1'b0; end
                                    OP_WRITE: begin
                                        phase <= PH_ADDR;
                                        is_wr <= 1'b1;
                                        pmask <= '0;
                                    end
                                    default: phase <= PH_IGNORE;
                                endcase
                            end
                        end
                        PH_ADDR: begin
                            if (!addr_stage) begin
                                addr_hi    <= byte_in;
                                addr_stage <= 1'b1;
                            end else begin
                                addr  <= ADDR_W'({addr_hi, byte_in});
                                phase <= is_wr ? PH_WDATA : PH_RDATA;
                            end
                        end
                        PH_RDATA: addr <= addr + 1'b1;
                        PH_WDATA: begin
                            pmask[addr[IW-1:0]] <= 1'b1;
                            addr[IW-1:0]        <= addr[IW-1:0] + 1'b1;
                        end
                        PH_SRDATA: begin
                            lock_new <= byte_in[3:2];
                            phase    <= PH_SRFULL;
                        end
                        default: ;
                    endcase
                end
            end else if (sck_fall) begin
                so_r <= tx_byte[~bit_cnt];
            end
        end
    end

    assign so    = so_r;
    assign so_oe = sel && !held && (phase == PH_RDATA || phase == PH_STOUT);

    assert_hold_freeze_R11: assert property (@(posedge clk) disable iff (rst)
        held |=> ($stable(bit_cnt) && $stable(phase)));
    assert_no_locked_store_R6: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> !region_locked(lock, mem_waddr[ADDR_W-1 -: 2]));
    assert_busy_needs_latch_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(wip) |-> wel);
    assert_wp_guard_R7: assert property (@(posedge clk) disable iff (rst)
        !$stable(lock) |-> $past(wp_ok));
    assert_busy_reject_R9: assert property (@(posedge clk) disable iff (rst)
        (wip && phase == PH_CMD && byte_done && byte_in != OP_RDSR) |=> phase == PH_IGNORE);

endmodule

// File: tb/sermem_spi_slave_test.sv
module sermem_spi_slave_test;
    localparam int AW    = 10;
    localparam int DEPTH = 2 ** AW;
    localparam int WRC   = 300;
    localparam int HALF  = 4;

    logic clk = 1'b0, rst = 1'b1;
    logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1, wp_n = 1'b1;
    logic so, so_oe;

    always #2.5 clk = ~clk;

    sermem_spi_slave #(.ADDR_W(AW), .PAGE_BYTES(32), .WR_CYCLES(WRC)) uut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si),
        .hold_n(hold_n), .wp_n(wp_n), .so(so), .so_oe(so_oe)
    );

    int nchk = 0, nbad = 0;
    logic mode3 = 1'b0;
    logic last_oe;
    logic [7:0] ref_mem [DEPTH];
    logic       known [DEPTH];
    logic [7:0] wbuf [64];
    logic [7:0] rbuf [64];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic lock_ref(input logic [1:0] l, input int a);
        if (l == 2'd3) return 1'b1;
        if (l == 2'd2) return a >= DEPTH / 2;
        if (l == 2'd1) return a >= (3 * DEPTH) / 4;
        return 1'b0;
    endfunction

    function automatic logic [7:0] stat_ref(input logic [1:0] l, input logic wl, input logic wp);
        return {4'b0000, l, wl, wp};
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_x(input logic b, output logic r);
        sck = 1'b0; si = b; tick(HALF);
        r = so; last_oe = so_oe;
        sck = 1'b1; tick(HALF);
    endtask

    task automatic byte_x(input logic [7:0] t, output logic [7:0] r);
        for (int i = 7; i >= 0; i--) begin
            logic rb;
            bit_x(t[i], rb);
            r[i] = rb;
        end
    endtask

    task automatic cs_on();
        sck = mode3; tick(HALF);
        cs_n = 1'b0; tick(HALF);
    endtask

    task automatic cs_off();
        tick(HALF); sck = mode3; tick(HALF);
        cs_n = 1'b1; tick(2 * HALF);
    endtask

    task automatic op1(input logic [7:0] op);
        logic [7:0] d;
        cs_on(); byte_x(op, d); cs_off();
    endtask

    task automatic rdsr(output logic [7:0] s);
        logic [7:0] d;
        cs_on(); byte_x(8'h05, d); byte_x(8'h00, s); cs_off();
    endtask

    task automatic wrsr(input logic [7:0] v);
        logic [7:0] d;
        cs_on(); byte_x(8'h01, d); byte_x(v, d); cs_off();
    endtask

    task automatic wr_page(input logic [15:0] a, input int n);
        logic [7:0] d;
        cs_on(); byte_x(8'h02, d); byte_x(a[15:8], d); byte_x(a[7:0], d);
        for (int i = 0; i < n; i++) byte_x(wbuf[i], d);
        cs_off();
    endtask

    task automatic rd_bytes(input logic [15:0] a, input int n);
        logic [7:0] d;
        cs_on(); byte_x(8'h03, d); byte_x(a[15:8], d); byte_x(a[7:0], d);
        for (int i = 0; i < n; i++) byte_x(8'h00, rbuf[i]);
        cs_off();
    endtask

    task automatic wait_ready(input string req);
        logic [7:0] s;
        s = 8'h01;
        for (int k = 0; k < 40; k++) begin
            rdsr(s);
            if (!s[0]) break;
        end
        chk(req, {31'd0, s[0]}, 32'd0);
    endtask

    // expected effect of a page write issued with latch wl and lock l
    task automatic model_write(input int a, input int n, input logic [1:0] l, input logic wl);
        int base, col;
        base = a & ~31;
        col  = a & 31;
        if (wl && n > 0 && !lock_ref(l, base)) begin
            for (int i = 0; i < n; i++) begin
                ref_mem[base + ((col + i) & 31)] = wbuf[i];
                known[base + ((col + i) & 31)]   = 1'b1;
            end
        end
    endtask

    task automatic check_page(input string req, input int a);
        int base;
        base = a & ~31;
        rd_bytes(16'(base), 32);
        for (int i = 0; i < 32; i++)
            if (known[base + i]) chk(req, {24'd0, rbuf[i]}, {24'd0, ref_mem[base + i]});
    endtask

    task automatic set_lock(input logic [1:0] l);
        op1(8'h06);
        wrsr({4'($urandom), l, 2'($urandom)});
        wait_ready("R8 lock update settles");
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

    initial begin : main
        logic [7:0] s, d, got;
        logic rb;
        void'($urandom(32'd41));
        for (int i = 0; i < DEPTH; i++) known[i] = 1'b0;
        tick(10); rst = 1'b0; tick(4);

        // R1 reset state
        chk("R1 so_oe deselected", {31'd0, so_oe}, 32'd0);
        rdsr(s); chk("R1 status after reset", {24'd0, s}, 32'h00);

        // R2 latch set/clear
        op1(8'h06); rdsr(s); chk("R2 WREN sets latch", {24'd0, s}, 32'h02);
        op1(8'h04); rdsr(s); chk("R2 WRDI clears latch", {24'd0, s}, 32'h00);

        // R4/R8 basic page write and busy window
        for (int i = 0; i < 4; i++) wbuf[i] = 8'($urandom);
        op1(8'h06); wr_page(16'h0040, 4); model_write('h40, 4, 2'd0, 1'b1);
        rdsr(s); chk("R8 busy and latch during cycle", {24'd0, s}, 32'h03);
        // R9 read issued during busy never drives so
        cs_on(); byte_x(8'h03, d); byte_x(8'h00, d); byte_x(8'h40, d); byte_x(8'h00, d);
        chk("R9 read ignored while busy", {31'd0, last_oe}, 32'd0);
        cs_off();
        wait_ready("R8 busy ends");
        rdsr(s); chk("R8 latch cleared after cycle", {24'd0, s}, 32'h00);
        check_page("R4 page data", 'h40);

        // R5 write without latch discarded
        wbuf[0] = ~ref_mem['h40];
        wr_page(16'h0040, 1);
        rdsr(s); chk("R5 no busy without latch", {24'd0, s}, 32'h00);
        check_page("R5 data kept", 'h40);

        // R4 wrap inside page from column 30
        for (int i = 0; i < 4; i++) wbuf[i] = 8'($urandom);
        op1(8'h06); wr_page(16'h009E, 4); model_write('h9E, 4, 2'd0, 1'b1);
        wait_ready("R8 wrap write done");
        check_page("R4 column wraps in page", 'h80);
        check_page("R4 next page untouched", 'hA0);

        // R3 address aliasing and end-of-array wrap
        wbuf[0] = 8'hC3; op1(8'h06); wr_page(16'(DEPTH - 1), 1); model_write(DEPTH - 1, 1, 2'd0, 1'b1);
        wait_ready("R8 end write");
        wbuf[0] = 8'h3C; op1(8'h06); wr_page(16'h0000, 1); model_write(0, 1, 2'd0, 1'b1);
        wait_ready("R8 zero write");
        rd_bytes(16'(DEPTH - 1), 2);
        chk("R3 last address", {24'd0, rbuf[0]}, 32'hC3);
        chk("R3 wrap to zero", {24'd0, rbuf[1]}, 32'h3C);
        rd_bytes(16'hFC40, 1);
        chk("R3 upper address bits ignored", {24'd0, rbuf[0]}, {24'd0, ref_mem['h40]});

        // R6 region locking
        set_lock(2'd1);
        rdsr(s); chk("R6 lock field top quarter", {24'd0, s}, 32'h04);
        wbuf[0] = 8'h11; op1(8'h06); wr_page(16'(DEPTH - 1), 1);
        rdsr(s); chk("R6 locked write rejected, latch kept", {24'd0, s}, 32'h06);
        op1(8'h04);
        rd_bytes(16'(DEPTH - 1), 1); chk("R6 quarter data kept", {24'd0, rbuf[0]}, 32'hC3);
        set_lock(2'd3);
        wbuf[0] = 8'h22; op1(8'h06); wr_page(16'h0000, 1);
        rdsr(s); chk("R6 all locked", {24'd0, s}, 32'h0E);
        rd_bytes(16'h0000, 1); chk("R6 zero data kept", {24'd0, rbuf[0]}, 32'h3C);

        // R7 write protect pin
        wp_n = 1'b0; wrsr(8'h00);
        rdsr(s); chk("R7 status write blocked by wp_n", {24'd0, s}, 32'h0E);
        wp_n = 1'b1; wrsr(8'h00); wait_ready("R7 status write busy");
        rdsr(s); chk("R7 status write accepted", {24'd0, s}, 32'h00);

        // R10 abort mid-byte
        op1(8'h06);
        cs_on(); byte_x(8'h02, d); byte_x(8'h00, d); byte_x(8'h40, d); byte_x(8'h5A, d);
        bit_x(1'b1, rb); bit_x(1'b0, rb); bit_x(1'b1, rb);
        cs_off();
        rdsr(s); chk("R10 abort starts no cycle", {24'd0, s}, 32'h02);
        op1(8'h04);
        check_page("R10 data kept after abort", 'h40);

        // R11 pause mid-read
        cs_on(); byte_x(8'h03, d); byte_x(8'h00, d); byte_x(8'h40, d);
        for (int i = 7; i >= 5; i--) begin bit_x(1'b0, rb); got[i] = rb; end
        sck = 1'b0; tick(HALF); hold_n = 1'b0; tick(HALF);
        chk("R11 so_oe low while paused", {31'd0, so_oe}, 32'd0);
        repeat (3) begin sck = 1'b1; si = ~si; tick(HALF); sck = 1'b0; tick(HALF); end
        hold_n = 1'b1; tick(HALF);
        for (int i = 4; i >= 0; i--) begin bit_x(1'b0, rb); got[i] = rb; end
        cs_off();
        chk("R11 byte intact across pause", {24'd0, got}, {24'd0, ref_mem['h40]});

        // random page writes under random locks, both clock polarities (R12)
        for (int it = 0; it < 10; it++) begin
            logic [1:0] l;
            logic [15:0] a;
            int n, ea;
            logic acc;
            mode3 = it[0];
            sck = mode3; tick(2 * HALF);
            l  = 2'($urandom);
            a  = 16'($urandom);
            ea = int'(a) % DEPTH;
            n  = 1 + int'($urandom % 40);
            set_lock(l);
            for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
            op1(8'h06); wr_page(a, n);
            acc = !lock_ref(l, ea & ~31);
            model_write(ea, n, l, 1'b1);
            wait_ready("R8 random write settles");
            rdsr(s);
            chk(mode3 ? "R12 status idle-high clock" : "R6 status after random write",
                {24'd0, s}, {24'd0, stat_ref(l, !acc, 1'b0)});
            op1(8'h04);
            check_page(mode3 ? "R12 page data idle-high clock" : "R6 page data", ea);
        end

        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

endmodule